// File: doc/BRIEF.md
# Look-ahead parallel LFSR sequence generator

This block generates the maximal-length pseudo-random bit stream of the seven-stage recurrence with feedback polynomial 1 + x^4 + x^7, the one used by common wireless scramblers. It delivers several bits per clock instead of one. The block does not run the seven-stage recurrence directly. It runs the recurrence of that polynomial raised to the power 2^LEVEL, which has the same three terms with every exponent multiplied by 2^LEVEL. The tap gaps therefore widen by 2^LEVEL. The shortest gap sets how many bits can be formed in one step with no dependence between them: 4, 8 or 16 for LEVEL 0, 1 or 2. Each output bit still costs one XOR gate. The price is a history register of 7·2^LEVEL bits.

After a seed is loaded, a start-up phase runs the plain seven-stage recurrence one bit per cycle until the whole history is filled. Only then does the block begin to emit words. A consumer drives `en` high whenever it takes a word. `dataValid` tells it whether the word on `dataOut` is real stream data. The bit stream, read word by word from bit 0 upward, is bit-identical to a serial LFSR started from the same seed.

Top module: `plfsr_lookahead`

## Requirements
- R1: With seed bits s0..s6 (`seedIn[i]` = s_i), the stream is y[i] = s_i for i < 7 and y[n] = y[n-4] XOR y[n-7] for n >= 7. Each valid word carries the next WORD_W stream bits, with the earliest bit on `dataOut[0]`. The first valid word after a fill starts at y[0].
- R2: WORD_W = 4·2^LEVEL. Once the fill is over, `dataValid` equals `en`. With `en` low, `dataOut` holds its word and the stream position does not advance.
- R3: The emitted stream repeats exactly with a period of 127 bits.
- R4: After an accepted load, `dataValid` stays low for exactly 7·(2^LEVEL − 1) cycles whatever `en` does, and the fill advances every cycle. At LEVEL 0 the first word is available in the cycle after the load.
- R5: A load with `seedIn` equal to zero is ignored. The stream position, the word on `dataOut` and the progress of any fill are unchanged.
- R6: Synchronous active-high `rst` acts as a load of the seed 7'b1111111, including the fill phase, and takes priority over `load`.
- R7: An accepted load takes priority over `en` and restarts the stream at y[0] of the new seed, whether the block is filling or running.
- R8: The internal history never becomes all zero, so no seven consecutive emitted bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; reseeds with all ones |
| load | input | 1 | Seed load strobe |
| seedIn | input | 7 | Seed, bit i is stream bit y[i]; zero is rejected |
| en | input | 1 | Consume the current word and advance |
| dataOut | output | WORD_W | Current stream word, earliest bit at bit 0 |
| dataValid | output | 1 | Word on dataOut is stream data and is taken this cycle |

## Verification
Any wrong bit in the history register shows up at the ports within one or two words. A history bit reaches `dataOut` directly within 7·2^LEVEL / WORD_W steps (at most two), or, through the taps, inside the next word. The bench therefore compares every word with a serially computed stream and would catch such a fault almost at once. Fill-length and restart errors show up as `dataValid` rising one cycle early or late, or as a first word that is not y[0]. A dropped or repeated shift shows up as a misaligned word and, over a longer run, as a break in the 127-bit period.

// File: rtl/plfsr_pkg.sv
package plfsr_pkg;
  localparam int BASE_ORDER = 7;
  localparam int BASE_TAP   = 4;
  localparam logic [BASE_ORDER-1:0] DEFAULT_SEED = 7'h7F;

  typedef enum logic {PH_FILL, PH_RUN} lfsrPhase_t;

  typedef struct packed {
    logic loadDefault;
    logic loadSeed;
    logic fillStep;
    logic runStep;
  } lfsrStrobes_t;
endpackage

// File: rtl/plfsr_ctrl.sv
module plfsr_ctrl
  import plfsr_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         seedNonZero,
  input  logic         en,
  output lfsrStrobes_t st,
  output logic         running
);
  localparam int FILL_LEN = BASE_ORDER * ((1 << LEVEL) - 1);
  localparam int CW = (FILL_LEN > 0) ? $clog2(FILL_LEN + 1) : 1;

  lfsrPhase_t phase;
  logic [CW-1:0] fillCnt;

  always_comb begin
    st.loadDefault = rst;
    st.loadSeed    = !rst && load && seedNonZero;
    st.fillStep    = !rst && !st.loadSeed && (phase == PH_FILL);
    st.runStep     = !rst && !st.loadSeed && (phase == PH_RUN) && en;
  end

  assign running = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (st.loadDefault || st.loadSeed) begin
      fillCnt <= CW'(FILL_LEN);
      phase   <= (FILL_LEN == 0) ? PH_RUN : PH_FILL;
    end else if (st.fillStep) begin
      fillCnt <= fillCnt - CW'(1);
      if (fillCnt == CW'(1)) phase <= PH_RUN;
    end
  end

  // R4: a fill phase always has cycles left to run
  a_r4_fill_counted: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL) |-> (fillCnt != '0));

  // R4: the fill and the word output never advance in the same cycle
  a_r4_fill_excludes_run: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.fillStep, st.runStep, st.loadSeed}));

  if (FILL_LEN == 0) begin : g_nofill
    a_r7_load_restarts: assert property (@(posedge clk) disable iff (rst)
      st.loadSeed |=> running);
  end else begin : g_fill
    a_r7_load_restarts: assert property (@(posedge clk) disable iff (rst)
      st.loadSeed |=> (!running && fillCnt == CW'(FILL_LEN)));
  end
endmodule

// File: rtl/plfsr_datapath.sv
module plfsr_datapath
  import plfsr_pkg::*;
#(
  parameter int LEVEL = 1,
  localparam int WORD_W = BASE_TAP << LEVEL
) (
  input  logic                  clk,
  input  lfsrStrobes_t          st,
  input  logic [BASE_ORDER-1:0] seed,
  output logic [WORD_W-1:0]     word
);
  localparam int HIST_W = BASE_ORDER << LEVEL;

  logic [HIST_W-1:0]     hist;
  logic [HIST_W-1:0]     seedFrame;
  logic [BASE_ORDER-1:0] selSeed;
  logic [WORD_W-1:0]     nextBits;
  logic                  fillBit;

  assign selSeed = st.loadDefault ? DEFAULT_SEED : seed;

  always_comb begin
    seedFrame = '0;
    seedFrame[HIST_W-1 -: BASE_ORDER] = selSeed;
  end

  // serial start-up recurrence on the newest seven bits at the top
  assign fillBit = hist[HIST_W-BASE_TAP] ^ hist[HIST_W-BASE_ORDER];

  // transformed recurrence: the word is formed from independent taps
  for (genvar k = 0; k < WORD_W; k++) begin : g_tap
    assign nextBits[k] = hist[k] ^ hist[HIST_W-WORD_W+k];
  end

  always_ff @(posedge clk) begin
    if (st.loadDefault || st.loadSeed) hist <= seedFrame;
    else if (st.fillStep) hist <= {fillBit, hist[HIST_W-1:1]};
    else if (st.runStep)  hist <= {nextBits, hist[HIST_W-1:WORD_W]};
  end

  assign word = hist[WORD_W-1:0];

  a_r8_state_nonzero: assert property (@(posedge clk) disable iff (st.loadDefault)
    hist != '0);

  a_r1_seed_placed: assert property (@(posedge clk) disable iff (st.loadDefault)
    st.loadSeed |=> (hist[HIST_W-1 -: BASE_ORDER] == $past(seed)));
endmodule

// File: rtl/plfsr_lookahead.sv
module plfsr_lookahead
  import plfsr_pkg::*;
#(
  parameter int LEVEL = 1,
  localparam int WORD_W = BASE_TAP << LEVEL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [BASE_ORDER-1:0] seedIn,
  input  logic                  en,
  output logic [WORD_W-1:0]     dataOut,
  output logic                  dataValid
);
  lfsrStrobes_t st;
  logic running;

  plfsr_ctrl #(.LEVEL(LEVEL)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .seedNonZero(seedIn != '0),
    .en(en), .st(st), .running(running)
  );

  plfsr_datapath #(.LEVEL(LEVEL)) u_dp (
    .clk(clk), .st(st), .seed(seedIn), .word(dataOut)
  );

  assign dataValid = running && en;

  a_r2_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> en);

  a_r5_zero_seed_ignored: assert property (@(posedge clk) disable iff (rst)
    (load && seedIn == '0 && !en && !st.fillStep) |=> $stable(dataOut));
endmodule

// File: tb/sim_plfsr_lookahead.sv
module sim_plfsr_lookahead;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, load, en;
  logic [6:0] seedIn;
  logic [3:0]  d0;
  logic [7:0]  d1;
  logic [15:0] d2;
  logic v0, v1, v2;

  plfsr_lookahead #(.LEVEL(0)) u0 (.clk(clk), .rst(rst), .load(load), .seedIn(seedIn),
    .en(en), .dataOut(d0), .dataValid(v0));
  plfsr_lookahead #(.LEVEL(1)) u1 (.clk(clk), .rst(rst), .load(load), .seedIn(seedIn),
    .en(en), .dataOut(d1), .dataValid(v1));
  plfsr_lookahead #(.LEVEL(2)) u2 (.clk(clk), .rst(rst), .load(load), .seedIn(seedIn),
    .en(en), .dataOut(d2), .dataValid(v2));

  int total = 0, bad = 0;
  bit refSeq[4096];
  bit cap[3][4096];
  int pos[3], fillLeft[3];
  bit run[3];
  string ctx = "R6";

  function automatic int wOf(int i); return 4 << i; endfunction
  function automatic int fOf(int i); return 7 * ((1 << i) - 1); endfunction

  task automatic buildRef(input logic [6:0] s);
    for (int n = 0; n < 7; n++) refSeq[n] = s[n];
    for (int n = 7; n < 4096; n++) refSeq[n] = refSeq[n-4] ^ refSeq[n-7];
  endtask

  task automatic restart();
    for (int i = 0; i < 3; i++) begin
      pos[i] = 0; fillLeft[i] = fOf(i); run[i] = (fOf(i) == 0);
    end
  endtask

  task automatic checkAll();
    logic [15:0] got, expW;
    logic gotV, expV;
    bit perBad, zeroRun;
    for (int i = 0; i < 3; i++) begin
      got = (i == 0) ? {12'b0, d0} : (i == 1) ? {8'b0, d1} : d2;
      gotV = (i == 0) ? v0 : (i == 1) ? v1 : v2;
      expV = run[i] && en;
      total++;
      if (gotV !== expV) begin
        bad++;
        $display("FAIL %s (%s) u%0d valid got=%b exp=%b", run[i] ? "R2" : "R4", ctx, i, gotV, expV);
      end
      if (run[i]) begin
        expW = '0;
        for (int k = 0; k < wOf(i); k++) expW[k] = refSeq[pos[i]+k];
        total++;
        if (got !== expW) begin
          bad++;
          $display("FAIL R1 (%s) u%0d word pos=%0d got=%h exp=%h", ctx, i, pos[i], got, expW);
        end
        for (int k = 0; k < wOf(i); k++) cap[i][pos[i]+k] = got[k];
        perBad = 0;
        if (pos[i] + wOf(i) > 127) begin
          for (int k = 0; k < wOf(i); k++)
            if (pos[i]+k >= 127 && cap[i][pos[i]+k] != cap[i][pos[i]+k-127]) perBad = 1;
          total++;
          if (perBad) begin
            bad++;
            $display("FAIL R3 u%0d period break near pos=%0d got=%h exp=%h", i, pos[i], got, expW);
          end
        end
        if (pos[i] + wOf(i) >= 7) begin
          zeroRun = 1;
          for (int k = 1; k <= 7; k++) if (cap[i][pos[i]+wOf(i)-k]) zeroRun = 0;
          total++;
          if (zeroRun) begin
            bad++;
            $display("FAIL R8 u%0d seven zero bits at pos=%0d got=%h exp=%s", i, pos[i], got, "nonzero");
          end
        end
      end
    end
  endtask

  task automatic stepModel();
    if (rst) begin buildRef(7'h7F); restart(); end
    else if (load && seedIn != 7'd0) begin buildRef(seedIn); restart(); end
    else begin
      for (int i = 0; i < 3; i++) begin
        if (!run[i]) begin
          fillLeft[i]--;
          if (fillLeft[i] == 0) run[i] = 1;
        end else if (en) pos[i] += wOf(i);
      end
    end
  endtask

  task automatic tick(input logic r, input logic l, input logic [6:0] s, input logic e);
    @(negedge clk);
    checkAll();
    rst = r; load = l; seedIn = s; en = e;
    stepModel();
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog got=%s exp=%s", "hung", "finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sinceLoad;
    int r;
    logic doLoad, doRst;
    logic [6:0] s;
    void'($urandom(1234));
    rst = 1; load = 0; seedIn = 0; en = 1;
    stepModel();
    tick(1, 0, 0, 1);
    // R6: reset state then default seed stream over more than two periods
    for (int c = 0; c < 100; c++) tick(0, 0, 0, 1);
    ctx = "R5";
    tick(0, 1, 7'd0, 0);
    tick(0, 0, 7'd0, 0);
    tick(0, 1, 7'd0, 1);
    tick(0, 0, 7'd0, 1);
    ctx = "R7";
    tick(0, 1, 7'h35, 1);
    for (int c = 0; c < 5; c++) tick(0, 0, 0, 0);
    tick(0, 1, 7'd0, 1);     // R5 during fill: fill must keep going
    tick(0, 1, 7'h01, 1);    // R7 reload in the middle of a fill
    for (int c = 0; c < 100; c++) tick(0, 0, 0, 1);
    ctx = "R6";
    tick(1, 1, 7'h22, 1);    // reset wins over load
    for (int c = 0; c < 40; c++) tick(0, 0, 0, 1);
    ctx = "R2";
    for (int c = 0; c < 150; c++) tick(0, 0, 0, ($urandom % 2) == 0);
    ctx = "R1";
    sinceLoad = 0;
    for (int c = 0; c < 3000; c++) begin
      r = int'($urandom);
      doRst = ($urandom % 700) == 0;
      doLoad = (sinceLoad > 200) || (($urandom % 64) == 0);
      s = (($urandom % 4) == 0) ? 7'd0 : 7'($urandom);
      if (sinceLoad > 200) s = s | 7'd1;
      if (doRst || (doLoad && s != 7'd0)) sinceLoad = 0; else sinceLoad++;
      tick(doRst, doLoad, s, (r % 4) != 0);
    end
    tick(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule